// File: doc/BRIEF.md
# Phase-Accumulator Fractional Frequency Divider

The block divides its input clock by a programmable, possibly fractional, ratio. A register of `ACC_W` bits adds an increment word to itself on every enabled clock and wraps modulo 2^ACC_W. Each wrap is an overflow of the addition, and each overflow produces one tick on the pulse output. The average tick rate is f_clk × increment / 2^ACC_W. The spacing between ticks varies by at most one clock when the ratio is not an integer.

The raw tick has an uneven duty cycle. A divide-by-two stage can be enabled by parameter. That stage flips a square output on every tick, which gives a 50% duty-cycle waveform at half the tick rate. The increment may be changed while the block runs. The accumulated phase carries over, so the new rate begins on the next addition with no restart.

Top module: `phase_acc_divider`

## Requirements
- R1: While `rst_ni` is low, the accumulator, `pulse_o` and `square_o` are all 0. The first enabled addition after reset starts from phase 0.
- R2: `pulse_o` is high for exactly the one cycle that follows an enabled clock edge at which the sum of accumulator and `incr_i` reaches or exceeds 2^ACC_W. In every other cycle it is low.
- R3: The accumulator keeps the low `ACC_W` bits of the sum. With `incr_i` = 2^k, a pulse therefore comes every 2^(ACC_W-k) enabled cycles, the first one after 2^(ACC_W-k) cycles from reset.
- R4: With `incr_i` = 0, no pulse appears and `square_o` keeps its value.
- R5: When `SQUARE_EN` = 1, `square_o` inverts at the same clock edge that raises `pulse_o` and holds at every other edge.
- R6: While `en_i` is low, no pulse is produced, `square_o` holds, and the accumulator phase is kept. After `en_i` returns high, the pulses continue from the held phase.
- R7: A new `incr_i` value is used by the next enabled addition. The phase reached so far is kept.
- R8: With `incr_i` = 2^ACC_W − 1, a pulse follows every enabled edge except one in each 2^ACC_W. That missing edge is the first one after reset.
- R9: With a non-power-of-two increment, the number of pulses after n enabled cycles from reset equals floor(n × incr_i / 2^ACC_W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| incr_i | input | ACC_W | Phase increment per enabled clock |
| pulse_o | output | 1 | One-cycle tick for each accumulator overflow |
| square_o | output | 1 | 50% duty output, toggled on each tick |

## Verification
The case that is hardest to reach from the ports is a run where the enable drops, or the increment changes, while the accumulator sits partway to an overflow. Only the later pulse timing shows whether the phase was kept. The stimulus first runs long enough to leave a known, non-zero residue. It then holds the enable low for several cycles, or swaps in a very different increment mid-run. A cycle-by-cycle reference phase in the bench, advanced only on enabled edges, predicts the exact edge of each following pulse and the level of the square output.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;
  localparam int unsigned DEF_ACC_W = 16;

  typedef enum logic [0:0] {
    SQ_OFF = 1'b0,
    SQ_ON  = 1'b1
  } sq_mode_e;
endpackage

// File: rtl/pad_accum.sv
module pad_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             ovf_o
);
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum     = {1'b0, acc_q} + {1'b0, incr_i};
  assign ovf_o   = en_i & sum[ACC_W];
  assign phase_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[ACC_W-1:0];
  end

  // R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));

  // R4
  zero_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i == '0) |-> !ovf_o);
endmodule

// File: rtl/pad_pulse.sv
module pad_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ovf_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= ovf_i;
  end

  assign pulse_o = pulse_q;

  // R6
  no_pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_q);
endmodule

// File: rtl/pad_square.sv
module pad_square #(
  parameter phase_acc_pkg::sq_mode_e MODE = phase_acc_pkg::SQ_ON
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  output logic square_o
);
  generate
    if (MODE == phase_acc_pkg::SQ_ON) begin : g_tff
      logic sq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    sq_q <= 1'b0;
        else if (ovf_i) sq_q <= ~sq_q;
      end
      assign square_o = sq_q;
    end else begin : g_off
      assign square_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/phase_acc_divider.sv
module phase_acc_divider #(
  parameter int unsigned ACC_W     = phase_acc_pkg::DEF_ACC_W,
  parameter bit          SQUARE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic             pulse_o,
  output logic             square_o
);
  import phase_acc_pkg::*;

  localparam sq_mode_e SQ_MODE = SQUARE_EN ? SQ_ON : SQ_OFF;

  logic [ACC_W-1:0] phase;
  logic             ovf;

  pad_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .incr_i (incr_i),
    .phase_o(phase),
    .ovf_o  (ovf)
  );

  pad_pulse u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .ovf_i  (ovf),
    .pulse_o(pulse_o)
  );

  pad_square #(.MODE(SQ_MODE)) u_square (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ovf_i   (ovf),
    .square_o(square_o)
  );

  // R2: a pulse means the phase wrapped below its previous value plus increment
  wrap_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(en_i) && ({1'b0, phase} != {1'b0, $past(phase)} + {1'b0, $past(incr_i)})));

  generate
    if (SQUARE_EN) begin : g_sq_chk
      // R5
      sq_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> (square_o != $past(square_o)));
      // R5
      sq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pulse_o |-> $stable(square_o));
    end
  endgenerate
endmodule

// File: tb/phase_acc_divider_test.sv
module phase_acc_divider_test;
  localparam int unsigned W      = 8;
  localparam int unsigned MODV   = 1 << W;
  localparam time         PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] incr;
  logic         pulse, square;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int unsigned m_acc;
  logic        m_sq;

  always #(PERIOD/2) clk = ~clk;

  phase_acc_divider #(.ACC_W(W), .SQUARE_EN(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .incr_i(incr),
    .pulse_o(pulse), .square_o(square)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; incr = '0;
    m_acc = 0; m_sq = 1'b0;
    repeat (2) @(negedge clk);
    chk(pulse == 1'b0, "R1 pulse", pulse, 0);
    chk(square == 1'b0, "R1 square", square, 0);
    rst_n = 1'b1;
  endtask

  // one clock; returns observed pulse, checks against reference
  task automatic step(input string req, output bit p);
    bit exp_p;
    @(posedge clk);
    exp_p = 1'b0;
    if (en) begin
      if (m_acc + incr >= MODV) exp_p = 1'b1;
      m_acc = (m_acc + incr) % MODV;
      if (exp_p) m_sq = ~m_sq;
    end
    @(negedge clk);
    p = pulse;
    chk(pulse == exp_p, {req, " pulse"}, pulse, exp_p);
    chk(square == m_sq, {req, " square"}, square, m_sq);
  endtask

  task automatic t_reset_start();
    bit p;
    do_reset();
    en = 1'b1; incr = 8'd128;
    step("R1", p);
    chk(p == 1'b0, "R1 first add from 0", p, 0);
    step("R1", p);
    chk(p == 1'b1, "R1 second add wraps", p, 1);
  endtask

  task automatic t_pow2_rate();
    bit p;
    int first, cnt;
    do_reset();
    en = 1'b1; incr = 8'd16;
    first = -1; cnt = 0;
    for (int i = 1; i <= 64; i++) begin
      step("R3", p);
      if (p) begin cnt++; if (first < 0) first = i; end
    end
    chk(first == 16, "R3 first pulse cycle", first, 16);
    chk(cnt == 4, "R3 pulse count", cnt, 4);
  endtask

  task automatic t_zero();
    bit p;
    int cnt = 0;
    do_reset();
    en = 1'b1; incr = 8'd200;
    repeat (3) step("R4", p);
    incr = '0;
    for (int i = 0; i < 40; i++) begin step("R4", p); if (p) cnt++; end
    chk(cnt == 0, "R4 no pulses at zero", cnt, 0);
  endtask

  task automatic t_enable();
    bit p;
    int cnt = 0;
    do_reset();
    en = 1'b1; incr = 8'd37;
    repeat (5) step("R6", p);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin step("R6", p); if (p) cnt++; end
    chk(cnt == 0, "R6 no pulse while disabled", cnt, 0);
    en = 1'b1;
    repeat (30) step("R6 resume", p);
  endtask

  task automatic t_change();
    bit p;
    do_reset();
    en = 1'b1; incr = 8'd5;
    repeat (20) step("R7", p);
    incr = 8'd200;
    repeat (10) step("R7 new incr", p);
    incr = 8'd1;
    repeat (10) step("R7 small incr", p);
  endtask

  task automatic t_max();
    bit p;
    int cnt = 0;
    do_reset();
    en = 1'b1; incr = 8'hFF;
    step("R8", p);
    chk(p == 1'b0, "R8 first edge no pulse", p, 0);
    for (int i = 0; i < 255; i++) begin step("R8", p); if (p) cnt++; end
    chk(cnt == 255, "R8 pulse count", cnt, 255);
    step("R8", p);
    chk(p == 1'b0, "R8 gap after wrap", p, 0);
  endtask

  task automatic t_fraction();
    bit p;
    int cnt = 0;
    do_reset();
    en = 1'b1; incr = 8'd3;
    for (int i = 0; i < 300; i++) begin step("R9", p); if (p) cnt++; end
    chk(cnt == (300 * 3) / 256, "R9 fractional count", cnt, (300 * 3) / 256);
    // R2: pulse spacing covered cycle by cycle in step
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; incr = '0;
    t_reset_start();
    t_pow2_rate();
    t_zero();
    t_enable();
    t_change();
    t_max();
    t_fraction();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule